// File: doc/BRIEF.md
# Two-Level Carry Lookahead Adder

A 16-bit combinational adder with a carry input. The operands are split into four 4-bit slices. Every bit forms its own generate term (both operand bits set) and propagate term (either operand bit set). Each slice turns these terms into the carries into its bits, written fully expanded, and also reports a slice-wide generate and a slice-wide propagate.

A second lookahead unit takes the four slice-wide terms and the adder's carry input. It forms the carry into every slice with the same expanded equations, so no carry is chained from one slice to the next. Each slice uses its incoming carry to form its internal bit carries. The sum bits are the XOR of the two operand bits and the carry into that bit. The carry output is the carry into bit 16.

The delay is fixed and shallow: one gate level for the bit terms, two for the slice terms, two for the slice carries, two for the bit carries and one for the sum. It does not grow with the length of a carry chain. The block holds no state and has no clock.

Top module: `cla16Adder`

## Requirements
- R1: For every pair of operands and either carry-in, `sumOut` equals the low 16 bits of opA + opB + carryIn.
- R2: `carryOut` equals bit 16 of opA + opB + carryIn.
- R3: A carry-in of 1 with opA = 0xFFFF and opB = 0x0000 propagates across all four slices: sumOut = 0x0000, carryOut = 1.
- R4: A carry generated inside the lowest slice crosses into the next slice: 0x000F + 0x0001 gives 0x0010 with carryOut = 0.
- R5: A generate in the top bit alone drives the carry output: 0x8000 + 0x8000 gives sumOut = 0x0000, carryOut = 1.
- R6: The block is combinational. Its outputs follow a change of inputs without any clock edge.
- R7: The carry into slice k+1 equals the slice-wide generate of slice k OR (its slice-wide propagate AND the carry into slice k). So 0x0FFF + 0x0001 gives 0x1000, and 0x00FF + 0xFF00 + 1 gives 0x0000 with carryOut = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 16 | First operand |
| opB | input | 16 | Second operand |
| carryIn | input | 1 | Carry into bit 0 |
| sumOut | output | 16 | Sum bits |
| carryOut | output | 1 | Carry out of bit 15 |

## Verification
The bench targets the carries that must pass through several slices at once.

- An all-ones operand with carry-in 1 needs every slice-wide propagate term. A design that loses a product term in the second-level unit returns a nonzero sum or drops the carry output.
- A carry generated at a slice boundary catches a design that feeds the wrong slice's generate, or leaves the incoming carry out of a slice. Such a design fails to carry into the next slice.
- Alternating patterns, a lone top-bit generate, and random operands under both carry-in values expose swapped generate and propagate terms and a mis-indexed sum bit.

// File: rtl/claPkg.sv
package claPkg;
  localparam int MAX_TERMS = 16;

  // Expanded lookahead carry into position k from generate/propagate vectors
  // and an incoming carry: OR of g[j] AND p[j+1..k-1], plus p[0..k-1] AND c0.
  function automatic logic expandCarry(input logic [MAX_TERMS-1:0] gen,
                                       input logic [MAX_TERMS-1:0] prop,
                                       input logic carry0, input int k);
    logic acc;
    logic term;
    acc = 1'b0;
    for (int j = 0; j < MAX_TERMS; j++) begin
      if (j < k) begin
        term = gen[j];
        for (int m = 0; m < MAX_TERMS; m++)
          if (m > j && m < k) term = term & prop[m];
        acc = acc | term;
      end
    end
    term = carry0;
    for (int m = 0; m < MAX_TERMS; m++)
      if (m < k) term = term & prop[m];
    return acc | term;
  endfunction
endpackage

// File: rtl/claBitGp.sv
module claBitGp #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [WIDTH-1:0] bitGen,
  output logic [WIDTH-1:0] bitProp
);
  for (genvar i = 0; i < WIDTH; i++) begin : gBit
    assign bitGen[i]  = opA[i] & opB[i];
    assign bitProp[i] = opA[i] | opB[i];
  end
endmodule

// File: rtl/claGroup.sv
module claGroup
  import claPkg::*;
#(
  parameter int GROUP_W = 4
) (
  input  logic [GROUP_W-1:0] bitGen,
  input  logic [GROUP_W-1:0] bitProp,
  input  logic               groupCin,
  output logic [GROUP_W-1:0] bitCarry,
  output logic               blkGen,
  output logic               blkProp
);
  localparam int PAD = MAX_TERMS - GROUP_W;
  logic [MAX_TERMS-1:0] genExt, propExt;

  assign genExt  = {{PAD{1'b0}}, bitGen};
  assign propExt = {{PAD{1'b0}}, bitProp};

  always_comb begin
    for (int k = 0; k < GROUP_W; k++)
      bitCarry[k] = expandCarry(genExt, propExt, groupCin, k);
    // slice-wide generate: carry out of the slice with a zero carry in
    blkGen  = expandCarry(genExt, propExt, 1'b0, GROUP_W);
    blkProp = &bitProp;
  end
endmodule

// File: rtl/claLookahead.sv
module claLookahead
  import claPkg::*;
#(
  parameter int GROUP_N = 4
) (
  input  logic [GROUP_N-1:0] blkGen,
  input  logic [GROUP_N-1:0] blkProp,
  input  logic               carryIn,
  output logic [GROUP_N:0]   groupCarry
);
  localparam int PAD = MAX_TERMS - GROUP_N;
  logic [MAX_TERMS-1:0] genExt, propExt;

  assign genExt  = {{PAD{1'b0}}, blkGen};
  assign propExt = {{PAD{1'b0}}, blkProp};

  always_comb begin
    for (int k = 0; k <= GROUP_N; k++)
      groupCarry[k] = expandCarry(genExt, propExt, carryIn, k);
  end
endmodule

// File: rtl/claSum.sv
module claSum #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [WIDTH-1:0] bitCarry,
  output logic [WIDTH-1:0] sumOut
);
  for (genvar i = 0; i < WIDTH; i++) begin : gSum
    assign sumOut[i] = opA[i] ^ opB[i] ^ bitCarry[i];
  end
endmodule

// File: rtl/cla16Adder.sv
module cla16Adder #(
  parameter int GROUP_W = 4,
  parameter int GROUP_N = 4
) (
  input  logic [GROUP_W*GROUP_N-1:0] opA,
  input  logic [GROUP_W*GROUP_N-1:0] opB,
  input  logic                       carryIn,
  output logic [GROUP_W*GROUP_N-1:0] sumOut,
  output logic                       carryOut
);
  localparam int WIDTH = GROUP_W * GROUP_N;

  logic [WIDTH-1:0]   bitGen, bitProp, bitCarry;
  logic [GROUP_N-1:0] blkGen, blkProp;
  logic [GROUP_N:0]   groupCarry;

  claBitGp #(.WIDTH(WIDTH)) u_bitGp (
    .opA(opA), .opB(opB), .bitGen(bitGen), .bitProp(bitProp)
  );

  for (genvar s = 0; s < GROUP_N; s++) begin : gSlice
    claGroup #(.GROUP_W(GROUP_W)) u_group (
      .bitGen  (bitGen[s*GROUP_W +: GROUP_W]),
      .bitProp (bitProp[s*GROUP_W +: GROUP_W]),
      .groupCin(groupCarry[s]),
      .bitCarry(bitCarry[s*GROUP_W +: GROUP_W]),
      .blkGen  (blkGen[s]),
      .blkProp (blkProp[s])
    );
  end

  claLookahead #(.GROUP_N(GROUP_N)) u_lookahead (
    .blkGen(blkGen), .blkProp(blkProp), .carryIn(carryIn),
    .groupCarry(groupCarry)
  );

  claSum #(.WIDTH(WIDTH)) u_sum (
    .opA(opA), .opB(opB), .bitCarry(bitCarry), .sumOut(sumOut)
  );

  assign carryOut = groupCarry[GROUP_N];
endmodule

// File: rtl/cla16AdderChecker.sv
module cla16AdderChecker #(
  parameter int GROUP_W = 4,
  parameter int GROUP_N = 4
) (
  input logic [GROUP_W*GROUP_N-1:0] opA,
  input logic [GROUP_W*GROUP_N-1:0] opB,
  input logic                       carryIn,
  input logic [GROUP_W*GROUP_N-1:0] sumOut,
  input logic                       carryOut,
  input logic [GROUP_N-1:0]         blkGen,
  input logic [GROUP_N-1:0]         blkProp,
  input logic [GROUP_N:0]           groupCarry
);
  localparam int WIDTH = GROUP_W * GROUP_N;
  logic [WIDTH:0] refSum;

  always_comb begin
    refSum = {1'b0, opA} + {1'b0, opB} + {{WIDTH{1'b0}}, carryIn};
    a_r1_sum_matches: assert (sumOut == refSum[WIDTH-1:0])
      else $error("R1 sum mismatch");
    a_r2_cout_matches: assert (carryOut == refSum[WIDTH])
      else $error("R2 carry out mismatch");
    a_r3_zero_carry_in_slice0: assert (groupCarry[0] == carryIn)
      else $error("R3 slice 0 carry");
    for (int k = 0; k < GROUP_N; k++) begin
      a_r7_slice_chain: assert (groupCarry[k+1] ==
                                (blkGen[k] | (blkProp[k] & groupCarry[k])))
        else $error("R7 slice carry chain");
    end
  end
endmodule

bind cla16Adder cla16AdderChecker #(.GROUP_W(GROUP_W), .GROUP_N(GROUP_N)) u_checker (
  .opA(opA), .opB(opB), .carryIn(carryIn), .sumOut(sumOut),
  .carryOut(carryOut), .blkGen(blkGen), .blkProp(blkProp),
  .groupCarry(groupCarry)
);

// File: tb/cla16Adder_bench.sv
module cla16Adder_bench;
  logic        clk = 1'b0;
  logic [15:0] opA = '0, opB = '0;
  logic        carryIn = 1'b0;
  logic [15:0] sumOut;
  logic        carryOut;
  int          nChecks = 0, nErrors = 0;
  bit          finished = 1'b0;

  always #4 clk = ~clk;

  cla16Adder u_cla16Adder (
    .opA(opA), .opB(opB), .carryIn(carryIn), .sumOut(sumOut), .carryOut(carryOut)
  );

  // entry: {a, b, cin, expected sum, expected carry out}
  localparam int NVEC = 15;
  localparam logic [49:0] VEC [NVEC] = '{
    {16'h0000, 16'h0000, 1'b0, 16'h0000, 1'b0},
    {16'h0000, 16'h0000, 1'b1, 16'h0001, 1'b0},
    {16'hFFFF, 16'h0000, 1'b1, 16'h0000, 1'b1},  // R3
    {16'hFFFF, 16'h0001, 1'b0, 16'h0000, 1'b1},
    {16'h000F, 16'h0001, 1'b0, 16'h0010, 1'b0},  // R4
    {16'h0FFF, 16'h0001, 1'b0, 16'h1000, 1'b0},  // R7
    {16'h8000, 16'h8000, 1'b0, 16'h0000, 1'b1},  // R5
    {16'hFFFF, 16'hFFFF, 1'b1, 16'hFFFF, 1'b1},
    {16'hFFFF, 16'hFFFF, 1'b0, 16'hFFFE, 1'b1},
    {16'h1234, 16'h4321, 1'b0, 16'h5555, 1'b0},
    {16'h7FFF, 16'h0001, 1'b0, 16'h8000, 1'b0},
    {16'h00FF, 16'hFF00, 1'b1, 16'h0000, 1'b1},  // R7
    {16'hAAAA, 16'h5555, 1'b0, 16'hFFFF, 1'b0},
    {16'hAAAA, 16'h5555, 1'b1, 16'h0000, 1'b1},
    {16'hF0F0, 16'h0F0F, 1'b1, 16'h0000, 1'b1}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s: actual=%0h expected=%0h (a=%h b=%h cin=%b)",
               tag, act, exp, opA, opB, carryIn);
    end
  endtask

  task automatic applyAndCheck(input string tag, input logic [15:0] a,
                               input logic [15:0] b, input logic cin);
    logic [16:0] expv;
    opA = a; opB = b; carryIn = cin;
    expv = {1'b0, a} + {1'b0, b} + {16'b0, cin};
    @(negedge clk);
    check({tag, " sum"}, {16'b0, sumOut}, {16'b0, expv[15:0]});
    check({tag, " cout"}, {31'b0, carryOut}, {31'b0, expv[16]});
  endtask

  initial begin
    // idle state: zero operands give zero outputs
    @(negedge clk);
    check("R1 idle sum", {16'b0, sumOut}, 32'h0);
    check("R2 idle cout", {31'b0, carryOut}, 32'h0);

    // R1/R2 vector table
    for (int i = 0; i < NVEC; i++) begin
      opA = VEC[i][49:34]; opB = VEC[i][33:18]; carryIn = VEC[i][17];
      @(negedge clk);
      check("R1 table sum", {16'b0, sumOut}, {16'b0, VEC[i][16:1]});
      check("R2 table cout", {31'b0, carryOut}, {31'b0, VEC[i][0]});
    end

    // directed corner cases
    applyAndCheck("R3 full propagate", 16'hFFFF, 16'h0000, 1'b1);
    applyAndCheck("R4 slice0 generate", 16'h000F, 16'h0001, 1'b0);
    applyAndCheck("R5 top generate", 16'h8000, 16'h8000, 1'b0);
    applyAndCheck("R7 three-slice carry", 16'h0FFF, 16'h0001, 1'b0);
    applyAndCheck("R7 propagate upper", 16'h00FF, 16'hFF00, 1'b1);
    for (int s = 0; s < 4; s++)
      applyAndCheck("R7 boundary", 16'hFFFF >> (16 - 4*(s+1)), 16'h0001, 1'b0);

    // R6: change inputs between edges and look without waiting for a clock
    @(posedge clk); #1;
    opA = 16'h0F0F; opB = 16'h00F1; carryIn = 1'b0;
    #1;
    check("R6 no clock sum", {16'b0, sumOut}, 32'h1000);
    check("R6 no clock cout", {31'b0, carryOut}, 32'h0);

    // R1/R2 random operands, both carry-in values for each pair
    for (int n = 0; n < 2000; n++) begin
      logic [15:0] ra, rb;
      ra = 16'($urandom); rb = 16'($urandom);
      applyAndCheck("R1 random cin0", ra, rb, 1'b0);
      applyAndCheck("R2 random cin1", ra, rb, 1'b1);
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChecks++; nErrors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
      $finish;
    end
  end
endmodule